// File: doc/BRIEF.md
# Operand-Snooping Reservation Station Group

This block holds the instructions waiting for one kind of execution unit in an out-of-order core. When the front end issues an operation, the group puts it in its lowest free slot. Each source operand arrives in one of two forms: as a value, or as the tag of the station that will produce it. A slot that still owes a value compares the result bus tag against its stored producer tag on every cycle. On a match it copies the bus data and zeroes that tag. A stored tag of zero means the operand is present, so no separate ready flag is kept.

Once both tags of a slot are zero, the slot is eligible to dispatch. The lowest-indexed eligible slot enters a pipelined execution unit, one slot per cycle. The unit adds or subtracts the operands and takes a fixed number of cycles. It sends the result out with the tag of the slot that produced it, and the slot is freed on the following clock edge. When every slot is occupied, the issue-ready output drops and the front end must hold the operation.

Top module: `rs_group`

## Requirements
- R1: After reset, `iss_ready_o` is 1 and `res_valid_o` is 0.
- R2: An operation issued with both producer tags zero appears on `res_valid_o` in the cycle that begins LAT+1 clock edges after the edge that accepted it, and not earlier. The edge that accepts the issue counts as the first of these.
- R3: Issue allocates the lowest-indexed free slot. The slot at index i reports results with tag TAG_BASE+i, so the defaults give tags 1, 2 and 3.
- R4: While all slots are busy, `iss_ready_o` is 0 and an asserted `iss_valid_i` is ignored: no slot is written and no result ever appears for that operation.
- R5: A waiting operand is filled from `cdb_data_i` when `cdb_valid_i` is 1 and `cdb_tag_i` equals its nonzero stored tag. Both operands of a slot may be filled by one broadcast. The slot then dispatches.
- R6: A broadcast whose tag matches no waiting operand changes nothing: the waiting slot produces no result.
- R7: If the bus carries the awaited tag in the same cycle that the operation is issued, the slot captures the value at allocation and does not wait.
- R8: When several slots are ready at once, they dispatch in ascending index order, one per cycle, so their results appear in consecutive cycles in that order.
- R9: A slot is freed on the edge that ends the cycle in which its result is on `res_valid_o`, so `iss_ready_o` can be 1 from the next cycle.
- R10: `iss_op_i` = 0 gives vj+vk and `iss_op_i` = 1 gives vj−vk, both modulo 2^DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | 1 | 0 add, 1 subtract |
| iss_vj_i | input | DATA_W | First operand value |
| iss_qj_i | input | TAG_W | First operand producer tag, 0 = value present |
| iss_vk_i | input | DATA_W | Second operand value |
| iss_qk_i | input | TAG_W | Second operand producer tag, 0 = value present |
| iss_ready_o | output | 1 | At least one slot is free |
| cdb_valid_i | input | 1 | Result bus carries a value |
| cdb_tag_i | input | TAG_W | Tag of the producing station |
| cdb_data_i | input | DATA_W | Result bus data |
| res_valid_o | output | 1 | This unit broadcasts a result |
| res_tag_o | output | TAG_W | Tag of the producing slot |
| res_data_o | output | DATA_W | Result value |

## Verification
A slot stuck with a nonzero tag shows up as a missing result. A slot that leaked a busy bit shows up as `iss_ready_o` staying low after its drain, and so does a free bit that was never cleared. In either case the fault is visible LAT+1 cycles after the broadcast or issue that should have released it. A wrong allocation or selection order is visible at once in the sequence of `res_tag_o` values across consecutive cycles. A missed capture at allocation leaves the operation waiting forever, so its result does not arrive at the expected cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    RS_OP_ADD = 1'b0,
    RS_OP_SUB = 1'b1
  } rs_op_e;
endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  rs_op_e            iss_op_i,
  input  logic [DATA_W-1:0] iss_vj_i,
  input  logic [TAG_W-1:0]  iss_qj_i,
  input  logic [DATA_W-1:0] iss_vk_i,
  input  logic [TAG_W-1:0]  iss_qk_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic              disp_i,
  input  logic              free_i,
  output logic              busy_o,
  output logic              ready_o,
  output rs_op_e            op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o
);
  logic              busy_q, sent_q;
  rs_op_e            op_q;
  logic [DATA_W-1:0] vj_q, vk_q, src_vj, src_vk, nxt_vj, nxt_vk;
  logic [TAG_W-1:0]  qj_q, qk_q, src_qj, src_qk, nxt_qj, nxt_qk;
  logic              hit_j, hit_k;

  // allocation path shares the snoop comparators with the waiting path
  always_comb begin
    src_qj = alloc_i ? iss_qj_i : qj_q;
    src_qk = alloc_i ? iss_qk_i : qk_q;
    src_vj = alloc_i ? iss_vj_i : vj_q;
    src_vk = alloc_i ? iss_vk_i : vk_q;
    hit_j  = cdb_valid_i && (src_qj != '0) && (cdb_tag_i == src_qj);
    hit_k  = cdb_valid_i && (src_qk != '0) && (cdb_tag_i == src_qk);
    nxt_qj = hit_j ? '0 : src_qj;
    nxt_qk = hit_k ? '0 : src_qk;
    nxt_vj = hit_j ? cdb_data_i : src_vj;
    nxt_vk = hit_k ? cdb_data_i : src_vk;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      op_q   <= RS_OP_ADD;
      qj_q   <= '0;
      qk_q   <= '0;
      vj_q   <= '0;
      vk_q   <= '0;
    end else begin
      if (alloc_i) begin
        busy_q <= 1'b1;
        sent_q <= 1'b0;
        op_q   <= iss_op_i;
      end else if (free_i) begin
        busy_q <= 1'b0;
        sent_q <= 1'b0;
      end else if (disp_i) begin
        sent_q <= 1'b1;
      end
      if (alloc_i || busy_q) begin
        qj_q <= nxt_qj;
        qk_q <= nxt_qk;
        vj_q <= nxt_vj;
        vk_q <= nxt_vk;
      end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !sent_q && (qj_q == '0) && (qk_q == '0);
  assign op_o    = op_q;
  assign vj_o    = vj_q;
  assign vk_o    = vk_q;

  a_r5_disp_needs_operands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_i |-> (busy_q && qj_q == '0 && qk_q == '0));

  a_r6_tag_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && qj_q != '0 && !(cdb_valid_i && cdb_tag_i == qj_q))
      |=> (qj_q == $past(qj_q)));

  a_r7_alloc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && cdb_valid_i && iss_qj_i != '0 && cdb_tag_i == iss_qj_i)
      |=> (qj_q == '0 && vj_q == $past(cdb_data_i)));

  a_r9_free_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |=> !busy_q);
endmodule

// File: rtl/rs_exec_pipe.sv
module rs_exec_pipe
  import rs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IW     = 2,
  parameter int LAT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [IW-1:0]     in_idx_i,
  input  rs_op_e            in_op_i,
  input  logic [DATA_W-1:0] in_vj_i,
  input  logic [DATA_W-1:0] in_vk_i,
  output logic              out_valid_o,
  output logic [IW-1:0]     out_idx_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              v_q   [LAT];
  logic [IW-1:0]     idx_q [LAT];
  logic [DATA_W-1:0] d_q   [LAT];
  logic [DATA_W-1:0] alu;

  assign alu = (in_op_i == RS_OP_SUB) ? (in_vj_i - in_vk_i) : (in_vj_i + in_vk_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q[0]   <= 1'b0;
      idx_q[0] <= '0;
      d_q[0]   <= '0;
    end else begin
      v_q[0]   <= in_valid_i;
      idx_q[0] <= in_idx_i;
      d_q[0]   <= alu;
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[s]   <= 1'b0;
        idx_q[s] <= '0;
        d_q[s]   <= '0;
      end else begin
        v_q[s]   <= v_q[s-1];
        idx_q[s] <= idx_q[s-1];
        d_q[s]   <= d_q[s-1];
      end
    end
  end

  assign out_valid_o = v_q[LAT-1];
  assign out_idx_o   = idx_q[LAT-1];
  assign out_data_o  = d_q[LAT-1];
endmodule

// File: rtl/rs_group.sv
module rs_group
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 3,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 1,
  parameter int LAT      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic              iss_op_i,
  input  logic [DATA_W-1:0] iss_vj_i,
  input  logic [TAG_W-1:0]  iss_qj_i,
  input  logic [DATA_W-1:0] iss_vk_i,
  input  logic [TAG_W-1:0]  iss_qk_i,
  output logic              iss_ready_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              res_valid_o,
  output logic [TAG_W-1:0]  res_tag_o,
  output logic [DATA_W-1:0] res_data_o
);
  localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

  logic [NUM_RS-1:0] busy_vec, ready_vec, free_gnt, disp_gnt, alloc_vec, free_vec;
  logic [IDX_W-1:0]  free_idx, disp_idx, res_idx;
  logic              any_free, any_ready;
  rs_op_e            op_arr [NUM_RS];
  logic [DATA_W-1:0] vj_arr [NUM_RS];
  logic [DATA_W-1:0] vk_arr [NUM_RS];
  rs_op_e            disp_op;
  logic [DATA_W-1:0] disp_vj, disp_vk;

  rs_prio_pick #(.N(NUM_RS), .IW(IDX_W)) u_alloc_pick (
    .req_i (~busy_vec),
    .gnt_o (free_gnt),
    .idx_o (free_idx),
    .any_o (any_free)
  );

  rs_prio_pick #(.N(NUM_RS), .IW(IDX_W)) u_disp_pick (
    .req_i (ready_vec),
    .gnt_o (disp_gnt),
    .idx_o (disp_idx),
    .any_o (any_ready)
  );

  assign iss_ready_o = any_free;
  assign alloc_vec   = (iss_valid_i && any_free) ? free_gnt : '0;

  for (genvar i = 0; i < NUM_RS; i++) begin : g_rs
    assign free_vec[i] = res_valid_o && (res_idx == IDX_W'(i));
    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_vec[i]),
      .iss_op_i    (rs_op_e'(iss_op_i)),
      .iss_vj_i    (iss_vj_i),
      .iss_qj_i    (iss_qj_i),
      .iss_vk_i    (iss_vk_i),
      .iss_qk_i    (iss_qk_i),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_data_i  (cdb_data_i),
      .disp_i      (disp_gnt[i]),
      .free_i      (free_vec[i]),
      .busy_o      (busy_vec[i]),
      .ready_o     (ready_vec[i]),
      .op_o        (op_arr[i]),
      .vj_o        (vj_arr[i]),
      .vk_o        (vk_arr[i])
    );
  end

  always_comb begin
    disp_op = RS_OP_ADD;
    disp_vj = '0;
    disp_vk = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (disp_gnt[i]) begin
        disp_op = op_arr[i];
        disp_vj = vj_arr[i];
        disp_vk = vk_arr[i];
      end
    end
  end

  rs_exec_pipe #(.DATA_W(DATA_W), .IW(IDX_W), .LAT(LAT)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (any_ready),
    .in_idx_i    (disp_idx),
    .in_op_i     (disp_op),
    .in_vj_i     (disp_vj),
    .in_vk_i     (disp_vk),
    .out_valid_o (res_valid_o),
    .out_idx_o   (res_idx),
    .out_data_o  (res_data_o)
  );

  assign res_tag_o = TAG_W'(TAG_BASE) + TAG_W'(res_idx);

  a_r2_result_owner_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> busy_vec[res_idx]);

  a_r3_alloc_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc_vec) && ((alloc_vec & busy_vec) == '0));

  a_r4_no_alloc_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&busy_vec && iss_valid_i) |-> (alloc_vec == '0));

  a_r8_single_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_gnt) && ((disp_gnt & ~ready_vec) == '0));
endmodule

// File: tb/sim_rs_group.sv
`timescale 1ns/1ps
module sim_rs_group;
  localparam int DW  = 64;
  localparam int TW  = 4;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          iss_valid = 1'b0, iss_op = 1'b0;
  logic [DW-1:0] iss_vj = '0, iss_vk = '0;
  logic [TW-1:0] iss_qj = '0, iss_qk = '0;
  logic          iss_ready;
  logic          cdb_valid = 1'b0;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;
  logic          res_valid;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  rs_group #(.NUM_RS(3), .DATA_W(DW), .TAG_W(TW), .TAG_BASE(1), .LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op),
    .iss_vj_i(iss_vj), .iss_qj_i(iss_qj), .iss_vk_i(iss_vk), .iss_qk_i(iss_qk),
    .iss_ready_o(iss_ready),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
    .res_valid_o(res_valid), .res_tag_o(res_tag), .res_data_o(res_data)
  );

  // {op, vj, vk, expected}
  localparam logic [192:0] VEC [6] = '{
    {1'b0, 64'd5,                  64'd7,                  64'd12},
    {1'b1, 64'd10,                 64'd3,                  64'd7},
    {1'b1, 64'd0,                  64'd1,                  64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1,                 64'd0},
    {1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0},
    {1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0001, 64'h1234_5678_9ABC_DEEF}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input logic op, input logic [DW-1:0] vj, input logic [TW-1:0] qj,
                       input logic [DW-1:0] vk, input logic [TW-1:0] qk);
    iss_valid = 1'b1; iss_op = op;
    iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
    @(posedge clk); @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic bus(input logic [TW-1:0] tag, input logic [DW-1:0] data);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_data = data;
    @(posedge clk); @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 ready", 64'(iss_ready), 64'd1);
    chk("R1 res_valid", 64'(res_valid), 64'd0);

    for (int n = 0; n < 6; n++) begin
      issue(VEC[n][192], VEC[n][191:128], '0, VEC[n][127:64], '0);
      repeat (LAT - 1) @(negedge clk);
      chk("R2 not early", 64'(res_valid), 64'd0);
      @(negedge clk);
      chk("R2 valid", 64'(res_valid), 64'd1);
      chk("R3 tag", 64'(res_tag), 64'd1);
      chk("R10 data", res_data, VEC[n][63:0]);
      @(negedge clk);
    end

    // fill all slots waiting on tag 9
    issue(1'b0, 64'd0, 4'd9, 64'd100, '0);
    issue(1'b0, 64'd0, 4'd9, 64'd200, '0);
    issue(1'b1, 64'd0, 4'd9, 64'd300, '0);
    chk("R4 full", 64'(iss_ready), 64'd0);
    issue(1'b0, 64'd5, '0, 64'd5, '0);   // must be dropped
    bus(4'd8, 64'hDEAD);
    for (int c = 0; c < LAT + 2; c++) begin
      @(negedge clk);
      chk("R6 no wakeup", 64'(res_valid), 64'd0);
    end
    bus(4'd9, 64'd1000);
    repeat (LAT - 1) @(negedge clk);
    @(negedge clk);
    chk("R8 first tag", 64'(res_tag), 64'd1);
    chk("R8 first data", res_data, 64'd1100);
    chk("R9 still full", 64'(iss_ready), 64'd0);
    @(negedge clk);
    chk("R8 second tag", 64'(res_tag), 64'd2);
    chk("R8 second data", res_data, 64'd1200);
    chk("R9 freed", 64'(iss_ready), 64'd1);
    @(negedge clk);
    chk("R8 third tag", 64'(res_tag), 64'd3);
    chk("R5 third data", res_data, 64'd700);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R4 dropped issue", 64'(res_valid), 64'd0);
    end

    // late second operand
    issue(1'b1, 64'd50, '0, 64'd0, 4'd7);
    for (int c = 0; c < LAT + 1; c++) begin
      @(negedge clk);
      chk("R5 waits", 64'(res_valid), 64'd0);
    end
    bus(4'd7, 64'd20);
    repeat (LAT) @(negedge clk);
    chk("R5 valid", 64'(res_valid), 64'd1);
    chk("R5 data", res_data, 64'd30);
    @(negedge clk);

    // both operands on one tag
    issue(1'b0, 64'd0, 4'd11, 64'd0, 4'd11);
    bus(4'd11, 64'd9);
    repeat (LAT) @(negedge clk);
    chk("R5 dual valid", 64'(res_valid), 64'd1);
    chk("R5 dual data", res_data, 64'd18);
    @(negedge clk);

    // broadcast coincides with allocation
    cdb_valid = 1'b1; cdb_tag = 4'd6; cdb_data = 64'd40;
    issue(1'b0, 64'd0, 4'd6, 64'd2, '0);
    cdb_valid = 1'b0;
    repeat (LAT) @(negedge clk);
    chk("R7 valid", 64'(res_valid), 64'd1);
    chk("R7 tag", 64'(res_tag), 64'd1);
    chk("R7 data", res_data, 64'd42);
    @(negedge clk);

    // async reset mid-flight
    issue(1'b0, 64'd1, 4'd3, 64'd1, '0);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", 64'(iss_ready), 64'd1);
    chk("R1 reset res", 64'(res_valid), 64'd0);

    finish_run();
  end
endmodule